// File: doc/BRIEF.md
# Kernel Launch Register Interface

This block is the register face of a compute engine's kernel launcher. A host uses a simple request/ready port to fill a byte-addressed descriptor buffer with the global and workgroup sizes of a kernel. It then writes the status word at the start of the window to start that kernel. The write data of that launch write is ignored. Reading the status word returns a flag that shows whether any kernel has ever been started.

On each launch a small engine takes the next kernel ID from a free-running counter and copies the six size fields out of the descriptor. It derives the workgroup count of each dimension by ceiling division on a shared sequential divider, one dimension after the other. It then multiplies the three counts into a total. The finished record is offered to a downstream dispatch queue and leaves the block only when that queue is not full. While the engine is working, descriptor traffic is still served, but a second launch write is held off by withholding ready.

Top module: `kl_launch_regs`

## Requirements
- R1: After reset the engine is idle, no record is pushed, the active flag and the outstanding-kernel count are 0, and every descriptor byte reads as 0.
- R2: A read of window offset 0 that is 8 bytes wide returns the active flag in bit 0 and zeros in bits 63:1. Any other read size at offset 0, and any access to offsets 1 to 7, completes with the error flag set.
- R3: A write at window offset 8 or above stores its low `size` bytes, little-endian, at descriptor byte (offset − 8). A read there returns those bytes in the same way, with unused upper bytes 0. If an access would pass the end of the descriptor (DESC_BYTES), it sets the error flag and changes nothing.
- R4: An access whose size is not 1, 2, 4 or 8, or whose address is outside [BASE_ADDR, BASE_ADDR+4096), sets the error flag and has no effect.
- R5: A write of legal size to offset 0 launches a kernel whatever its data. Kernel IDs start at 0 and rise by 1 per launch.
- R6: The descriptor holds three 32-bit little-endian global sizes (x, y, z) at descriptor bytes 0, 4 and 8, and three workgroup sizes at bytes 12, 16 and 20. The per-dimension count is ceil(global / workgroup). A workgroup size of 0 gives a count of 0.
- R7: The record total equals the product of the three per-dimension counts, kept at full width (3 × DIM_W bits).
- R8: Every launch sets the active flag, which then stays set, and increments the outstanding-kernel count.
- R9: The engine is busy from the accepted launch until its record has been pushed. A launch write during that time gets no ready until the engine is idle again, while descriptor and status accesses complete in the cycle they are presented.
- R10: `rec_push` is high only when `q_full` is low. While the record waits, all record fields hold still. Each launch yields exactly one push.
- R11: Descriptor writes made while a kernel is being computed or waiting do not change that kernel's record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_req | input | 1 | Host access request, held until ready |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_addr | input | AW | Byte address |
| hst_size | input | 4 | Access size in bytes |
| hst_wdata | input | 64 | Write data, little-endian |
| hst_ready | output | 1 | Access completes on this cycle |
| hst_err | output | 1 | Completing access was illegal |
| hst_rdata | output | 64 | Read data, valid with ready |
| q_full | input | 1 | Downstream dispatch queue cannot take a record |
| rec_push | output | 1 | Launch record is written to the queue |
| rec_id | output | ID_W | Kernel ID of the record |
| rec_cnt_x | output | DIM_W | Workgroups in x |
| rec_cnt_y | output | DIM_W | Workgroups in y |
| rec_cnt_z | output | DIM_W | Workgroups in z |
| rec_total | output | 3*DIM_W | Total workgroups |
| eng_busy | output | 1 | Launch engine working or waiting to push |
| disp_active | output | 1 | Active flag |
| kern_outst | output | OUT_W | Outstanding-kernel count |

## Verification
The two functions that can meet in one cycle are the downstream push of a finished record and the acceptance of the next launch write. The bench holds `q_full` high until a record is waiting, rewrites the descriptor under it, and then presents a second launch while the queue is still full. It releases the queue twenty cycles later. It then checks that the waiting record kept the first descriptor's values, that the push came only once `q_full` fell, that the held launch got ready only after that push, and that the second kernel carries the next ID and the rewritten sizes.

// File: rtl/kl_pkg.sv
package kl_pkg;

    typedef enum logic [1:0] {
        ACC_RD_STATUS,
        ACC_LAUNCH,
        ACC_DESC,
        ACC_BAD
    } kl_acc_e;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_DIV,
        ENG_MUL,
        ENG_PUSH
    } kl_eng_e;

    localparam int unsigned FIELD_BYTES = 4;
    localparam int unsigned NUM_DIMS    = 3;

endpackage

// File: rtl/kl_acc_decode.sv
module kl_acc_decode
    import kl_pkg::*;
#(
    parameter int unsigned AW         = 32,
    parameter logic [AW-1:0] BASE_ADDR = 32'h0000_4000,
    parameter int unsigned WIN_BYTES  = 4096,
    parameter int unsigned DESC_BYTES = 32,
    localparam int unsigned OFF_W     = $clog2(WIN_BYTES)
) (
    input  logic [AW-1:0]    addr,
    input  logic [3:0]       size,
    input  logic             we,
    output kl_acc_e          cls,
    output logic [OFF_W-1:0] desc_off
);

    logic [AW-1:0]    rel;
    logic [OFF_W-1:0] off;
    logic             in_win;
    logic             size_ok;

    always_comb begin
        rel      = addr - BASE_ADDR;
        in_win   = (addr >= BASE_ADDR) && (rel < AW'(WIN_BYTES));
        off      = rel[OFF_W-1:0];
        desc_off = off - OFF_W'(8);
        size_ok  = (size == 4'd1) || (size == 4'd2) || (size == 4'd4) || (size == 4'd8);

        if (!in_win || !size_ok) begin
            cls = ACC_BAD;
        end else if (off == '0) begin
            if (we)                cls = ACC_LAUNCH;
            else if (size == 4'd8) cls = ACC_RD_STATUS;
            else                   cls = ACC_BAD;
        end else if (off < OFF_W'(8)) begin
            cls = ACC_BAD;
        end else if ((int'(off) - 8 + int'(size)) <= int'(DESC_BYTES)) begin
            cls = ACC_DESC;
        end else begin
            cls = ACC_BAD;
        end
    end

endmodule

// File: rtl/kl_desc_buf.sv
module kl_desc_buf #(
    parameter int unsigned DESC_BYTES = 32,
    parameter int unsigned OFF_W      = 12,
    parameter int unsigned FLD_BYTES  = 24,
    localparam int unsigned IW        = $clog2(DESC_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [OFF_W-1:0]       off,
    input  logic [3:0]             size,
    input  logic [63:0]            wdata,
    output logic [63:0]            rdata,
    output logic [8*FLD_BYTES-1:0] fields
);

    logic [7:0] byte_d [DESC_BYTES];
    logic [7:0] byte_q [DESC_BYTES];

    for (genvar i = 0; i < DESC_BYTES; i++) begin : g_byte
        logic       hit;
        logic [2:0] lane;
        always_comb begin
            hit  = wr_en && (i >= int'(off)) && (i < int'(off) + int'(size));
            lane = 3'(i - int'(off));
            byte_d[i] = hit ? wdata[8*lane +: 8] : byte_q[i];
        end
    end

    for (genvar f = 0; f < FLD_BYTES; f++) begin : g_fld
        assign fields[8*f +: 8] = byte_q[f];
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < 8; k++) begin
            logic [OFF_W-1:0] idx;
            idx = off + OFF_W'(k);
            if ((k < int'(size)) && (int'(idx) < int'(DESC_BYTES))) begin
                rdata[8*k +: 8] = byte_q[idx[IW-1:0]];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DESC_BYTES; i++) byte_q[i] <= '0;
        end else begin
            for (int i = 0; i < DESC_BYTES; i++) byte_q[i] <= byte_d[i];
        end
    end

endmodule

// File: rtl/kl_ceil_div.sv
module kl_ceil_div #(
    parameter int unsigned W  = 32,
    localparam int unsigned CW = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] res
);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
        logic [W:0]    rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  dvs;
        logic          done;
        logic [W-1:0]  res;
    } div_t;

    div_t q, d;

    logic [W:0]   sh;
    logic         ge;
    logic [W:0]   rem_n;
    logic [W-1:0] quo_n;

    always_comb begin
        sh    = {q.rem[W-1:0], q.quo[W-1]};
        ge    = sh >= {1'b0, q.dvs};
        rem_n = ge ? (sh - {1'b0, q.dvs}) : sh;
        quo_n = {q.quo[W-2:0], ge};

        d      = q;
        d.done = 1'b0;
        if (start) begin
            d.rem = '0;
            d.quo = num;
            d.dvs = den;
            d.cnt = CW'(W);
            if (den == '0) begin
                d.run  = 1'b0;
                d.done = 1'b1;
                d.res  = '0;
            end else begin
                d.run = 1'b1;
            end
        end else if (q.run) begin
            d.rem = rem_n;
            d.quo = quo_n;
            d.cnt = q.cnt - CW'(1);
            if (q.cnt == CW'(1)) begin
                d.run  = 1'b0;
                d.done = 1'b1;
                d.res  = quo_n + W'(rem_n != '0);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = q.run;
    assign done = q.done;
    assign res  = q.res;

    AST_DIV_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !q.run); // R6
    AST_DIV_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done); // R6

endmodule

// File: rtl/kl_launch_regs.sv
module kl_launch_regs
    import kl_pkg::*;
#(
    parameter int unsigned   AW         = 32,
    parameter logic [AW-1:0] BASE_ADDR  = 32'h0000_4000,
    parameter int unsigned   DESC_BYTES = 32,
    parameter int unsigned   DIM_W      = 32,
    parameter int unsigned   ID_W       = 8,
    parameter int unsigned   OUT_W      = 16,
    localparam int unsigned  TOT_W      = NUM_DIMS * DIM_W,
    localparam int unsigned  WIN_BYTES  = 4096,
    localparam int unsigned  OFF_W      = $clog2(WIN_BYTES),
    localparam int unsigned  FLD_BYTES  = 2 * NUM_DIMS * FIELD_BYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hst_req,
    input  logic             hst_we,
    input  logic [AW-1:0]    hst_addr,
    input  logic [3:0]       hst_size,
    input  logic [63:0]      hst_wdata,
    output logic             hst_ready,
    output logic             hst_err,
    output logic [63:0]      hst_rdata,
    input  logic             q_full,
    output logic             rec_push,
    output logic [ID_W-1:0]  rec_id,
    output logic [DIM_W-1:0] rec_cnt_x,
    output logic [DIM_W-1:0] rec_cnt_y,
    output logic [DIM_W-1:0] rec_cnt_z,
    output logic [TOT_W-1:0] rec_total,
    output logic             eng_busy,
    output logic             disp_active,
    output logic [OUT_W-1:0] kern_outst
);

    typedef struct packed {
        kl_eng_e                          st;
        logic [1:0]                       dim;
        logic                             start;
        logic [NUM_DIMS-1:0][DIM_W-1:0]   gs;
        logic [NUM_DIMS-1:0][DIM_W-1:0]   ws;
        logic [NUM_DIMS-1:0][DIM_W-1:0]   cnt;
        logic [TOT_W-1:0]                 total;
        logic [ID_W-1:0]                  id;
        logic [ID_W-1:0]                  next_id;
        logic                             active;
        logic [OUT_W-1:0]                 outst;
    } eng_t;

    eng_t q, d;

    kl_acc_e                cls;
    logic [OFF_W-1:0]       desc_off;
    logic [63:0]            desc_rdata;
    logic [8*FLD_BYTES-1:0] fields;
    logic                   desc_wr;
    logic                   launch_acc;
    logic                   div_busy;
    logic                   div_done;
    logic [DIM_W-1:0]       div_res;

    kl_acc_decode #(
        .AW(AW), .BASE_ADDR(BASE_ADDR), .WIN_BYTES(WIN_BYTES), .DESC_BYTES(DESC_BYTES)
    ) u_dec (
        .addr(hst_addr), .size(hst_size), .we(hst_we), .cls(cls), .desc_off(desc_off)
    );

    kl_desc_buf #(
        .DESC_BYTES(DESC_BYTES), .OFF_W(OFF_W), .FLD_BYTES(FLD_BYTES)
    ) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(desc_wr), .off(desc_off), .size(hst_size),
        .wdata(hst_wdata), .rdata(desc_rdata), .fields(fields)
    );

    kl_ceil_div #(.W(DIM_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(q.start), .num(q.gs[q.dim]), .den(q.ws[q.dim]),
        .busy(div_busy), .done(div_done), .res(div_res)
    );

    // Host side: ready is withheld only for a launch that meets a busy engine.
    always_comb begin
        hst_ready  = hst_req && !(hst_we && (cls == ACC_LAUNCH) && (q.st != ENG_IDLE));
        hst_err    = hst_req && (cls == ACC_BAD);
        desc_wr    = hst_req && hst_we && (cls == ACC_DESC);
        launch_acc = hst_req && hst_we && (cls == ACC_LAUNCH) && (q.st == ENG_IDLE);
        case (cls)
            ACC_RD_STATUS: hst_rdata = {63'd0, q.active};
            ACC_DESC:      hst_rdata = hst_we ? 64'd0 : desc_rdata;
            default:       hst_rdata = 64'd0;
        endcase
    end

    // Launch engine.
    always_comb begin
        d       = q;
        d.start = 1'b0;
        case (q.st)
            ENG_IDLE: begin
                if (launch_acc) begin
                    for (int k = 0; k < int'(NUM_DIMS); k++) begin
                        d.gs[k] = fields[8*FIELD_BYTES*k +: DIM_W];
                        d.ws[k] = fields[8*FIELD_BYTES*(k+NUM_DIMS) +: DIM_W];
                    end
                    d.id      = q.next_id;
                    d.next_id = q.next_id + 1'b1;
                    d.active  = 1'b1;
                    d.outst   = q.outst + 1'b1;
                    d.dim     = 2'd0;
                    d.start   = 1'b1;
                    d.st      = ENG_DIV;
                end
            end
            ENG_DIV: begin
                if (div_done) begin
                    d.cnt[q.dim] = div_res;
                    if (q.dim == 2'(NUM_DIMS - 1)) begin
                        d.st = ENG_MUL;
                    end else begin
                        d.dim   = q.dim + 2'd1;
                        d.start = 1'b1;
                    end
                end
            end
            ENG_MUL: begin
                d.total = TOT_W'(q.cnt[0]) * TOT_W'(q.cnt[1]) * TOT_W'(q.cnt[2]);
                d.st    = ENG_PUSH;
            end
            ENG_PUSH: begin
                if (!q_full) d.st = ENG_IDLE;
            end
            default: d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rec_push    = (q.st == ENG_PUSH) && !q_full;
    assign rec_id      = q.id;
    assign rec_cnt_x   = q.cnt[0];
    assign rec_cnt_y   = q.cnt[1];
    assign rec_cnt_z   = q.cnt[2];
    assign rec_total   = q.total;
    assign eng_busy    = (q.st != ENG_IDLE);
    assign disp_active = q.active;
    assign kern_outst  = q.outst;

    AST_ID_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        launch_acc |=> (q.next_id == $past(q.next_id) + 1'b1)); // R5
    AST_OUTST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        launch_acc |=> (q.outst == $past(q.outst) + 1'b1)); // R8
    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        q.active |=> q.active); // R8
    AST_LAUNCH_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        launch_acc |=> (q.st == ENG_DIV) && q.start); // R9
    AST_DIV_IDLE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        q.start |-> !div_busy); // R6
    AST_REC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ENG_PUSH) && q_full) |=> ((q.st == ENG_PUSH) && $stable(q.total)
                                            && $stable(q.id) && $stable(q.cnt))); // R10
    AST_ONE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        rec_push |=> !rec_push); // R10

endmodule

// File: tb/kl_launch_regs_tb.sv
module kl_launch_regs_tb;

    localparam logic [31:0] BASE = 32'h0000_4000;
    localparam int NV = 8;

    localparam logic [31:0] TV_G [NV][3] = '{
        '{32'd64, 32'd1, 32'd1},
        '{32'd100, 32'd30, 32'd7},
        '{32'd1, 32'd1, 32'd1},
        '{32'd0, 32'd5, 32'd5},
        '{32'd1000, 32'd17, 32'd3},
        '{32'hFFFF_FFFF, 32'd1, 32'd1},
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd2},
        '{32'd1023, 32'd1025, 32'd4096}
    };
    localparam logic [31:0] TV_W [NV][3] = '{
        '{32'd16, 32'd1, 32'd1},
        '{32'd16, 32'd8, 32'd7},
        '{32'd256, 32'd256, 32'd256},
        '{32'd4, 32'd5, 32'd5},
        '{32'd0, 32'd4, 32'd1},
        '{32'd1, 32'd1, 32'd1},
        '{32'd2, 32'h8000_0000, 32'd2},
        '{32'd1024, 32'd1024, 32'd1024}
    };
    localparam logic [31:0] TV_C [NV][3] = '{
        '{32'd4, 32'd1, 32'd1},
        '{32'd7, 32'd4, 32'd1},
        '{32'd1, 32'd1, 32'd1},
        '{32'd0, 32'd1, 32'd1},
        '{32'd0, 32'd5, 32'd3},
        '{32'hFFFF_FFFF, 32'd1, 32'd1},
        '{32'h8000_0000, 32'd2, 32'd1},
        '{32'd1, 32'd2, 32'd4}
    };
    localparam logic [95:0] TV_T [NV] = '{
        96'd4, 96'd28, 96'd1, 96'd0, 96'd0, 96'hFFFF_FFFF, 96'h1_0000_0000, 96'd8
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_req = 1'b0;
    logic        hst_we = 1'b0;
    logic [31:0] hst_addr = '0;
    logic [3:0]  hst_size = '0;
    logic [63:0] hst_wdata = '0;
    logic        hst_ready, hst_err;
    logic [63:0] hst_rdata;
    logic        q_full = 1'b0;
    logic        rec_push;
    logic [7:0]  rec_id;
    logic [31:0] rec_cnt_x, rec_cnt_y, rec_cnt_z;
    logic [95:0] rec_total;
    logic        eng_busy, disp_active;
    logic [15:0] kern_outst;

    int n_chk = 0;
    int n_bad = 0;
    int pushes = 0;
    int launches = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    kl_launch_regs u_dut (
        .clk(clk), .rst_n(rst_n), .hst_req(hst_req), .hst_we(hst_we), .hst_addr(hst_addr),
        .hst_size(hst_size), .hst_wdata(hst_wdata), .hst_ready(hst_ready), .hst_err(hst_err),
        .hst_rdata(hst_rdata), .q_full(q_full), .rec_push(rec_push), .rec_id(rec_id),
        .rec_cnt_x(rec_cnt_x), .rec_cnt_y(rec_cnt_y), .rec_cnt_z(rec_cnt_z),
        .rec_total(rec_total), .eng_busy(eng_busy), .disp_active(disp_active),
        .kern_outst(kern_outst)
    );

    always @(posedge clk) if (rst_n && rec_push) pushes++;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic acc(input bit we, input logic [31:0] addr, input logic [3:0] sz,
                       input logic [63:0] wd, output logic [63:0] rd, output bit er,
                       output int waits);
        @(negedge clk);
        hst_req = 1'b1; hst_we = we; hst_addr = addr; hst_size = sz; hst_wdata = wd;
        waits = 0;
        #1;
        while (!hst_ready && waits < 2000) begin
            @(negedge clk);
            #1;
            waits++;
        end
        rd = hst_rdata;
        er = hst_err;
        @(posedge clk);
        #1;
        hst_req = 1'b0; hst_we = 1'b0;
    endtask

    task automatic wr(input logic [31:0] addr, input logic [3:0] sz, input logic [63:0] wd,
                      output bit er);
        logic [63:0] rd;
        int w;
        acc(1'b1, addr, sz, wd, rd, er, w);
    endtask

    task automatic rdd(input logic [31:0] addr, input logic [3:0] sz, output logic [63:0] rd,
                       output bit er);
        int w;
        acc(1'b0, addr, sz, 64'd0, rd, er, w);
    endtask

    task automatic load_desc(input logic [31:0] g [3], input logic [31:0] w [3]);
        bit er;
        for (int k = 0; k < 3; k++) begin
            wr(BASE + 32'd8 + 32'(4*k), 4'd4, {32'd0, g[k]}, er);
            wr(BASE + 32'd20 + 32'(4*k), 4'd4, {32'd0, w[k]}, er);
        end
    endtask

    task automatic wait_push(output bit got);
        int n = 0;
        got = 1'b0;
        @(negedge clk);
        #1;
        while (!rec_push && n < 2000) begin
            @(negedge clk);
            #1;
            n++;
        end
        got = rec_push;
    endtask

    task automatic chk_rec(input string tag, input logic [7:0] id, input logic [31:0] c [3],
                           input logic [95:0] t);
        chk(rec_id == id, {tag, " id"}, 128'(rec_id), 128'(id));
        chk(rec_cnt_x == c[0], {tag, " cnt_x"}, 128'(rec_cnt_x), 128'(c[0]));
        chk(rec_cnt_y == c[1], {tag, " cnt_y"}, 128'(rec_cnt_y), 128'(c[1]));
        chk(rec_cnt_z == c[2], {tag, " cnt_z"}, 128'(rec_cnt_z), 128'(c[2]));
        chk(rec_total == t, {tag, " total R7"}, 128'(rec_total), 128'(t));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] rd;
        bit er, got;
        int w1, w2;
        logic [7:0] exp_id = 8'd0;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk); #1;
        chk(!eng_busy && !rec_push && !disp_active && kern_outst == 16'd0 && !hst_ready,
            "R1 reset outputs", 128'({eng_busy, rec_push, disp_active, hst_ready}), 128'd0);
        rdd(BASE + 32'd8, 4'd8, rd, er);
        chk(rd == 64'd0 && !er, "R1 descriptor reset", 128'(rd), 128'd0);

        // R2: status word
        rdd(BASE, 4'd8, rd, er);
        chk(rd == 64'd0 && !er, "R2 status idle", 128'(rd), 128'd0);
        rdd(BASE, 4'd4, rd, er);
        chk(er, "R2 narrow status read err", 128'(er), 128'd1);
        rdd(BASE + 32'd3, 4'd1, rd, er);
        chk(er, "R2 offset 3 err", 128'(er), 128'd1);

        // R3: descriptor byte access
        wr(BASE + 32'd8, 4'd8, 64'h8877_6655_4433_2211, er);
        chk(!er, "R3 write ok", 128'(er), 128'd0);
        rdd(BASE + 32'd8, 4'd8, rd, er);
        chk(rd == 64'h8877_6655_4433_2211, "R3 readback 8", 128'(rd), 128'h8877665544332211);
        rdd(BASE + 32'd11, 4'd1, rd, er);
        chk(rd == 64'h44, "R3 readback byte 3", 128'(rd), 128'h44);
        rdd(BASE + 32'd14, 4'd2, rd, er);
        chk(rd == 64'h8877, "R3 readback half", 128'(rd), 128'h8877);
        wr(BASE + 32'd36, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, er);
        chk(er, "R3 overrun err", 128'(er), 128'd1);
        rdd(BASE + 32'd36, 4'd4, rd, er);
        chk(rd == 64'd0 && !er, "R3 overrun no effect", 128'(rd), 128'd0);
        wr(BASE + 32'd32, 4'd8, 64'hA5A5_0000_0000_5A5A, er);
        rdd(BASE + 32'd32, 4'd8, rd, er);
        chk(rd == 64'hA5A5_0000_0000_5A5A && !er, "R3 last legal slot", 128'(rd),
            128'hA5A500000000_5A5A);

        // R4: illegal size and address
        wr(BASE + 32'd8, 4'd3, 64'd0, er);
        chk(er, "R4 size 3 err", 128'(er), 128'd1);
        wr(BASE + 32'd8, 4'd0, 64'd0, er);
        chk(er, "R4 size 0 err", 128'(er), 128'd1);
        rdd(BASE + 32'd8, 4'd8, rd, er);
        chk(rd == 64'h8877_6655_4433_2211, "R4 bad size no effect", 128'(rd),
            128'h8877665544332211);
        rdd(BASE - 32'd8, 4'd8, rd, er);
        chk(er, "R4 below window err", 128'(er), 128'd1);
        wr(BASE + 32'd4096, 4'd8, 64'd0, er);
        chk(er, "R4 above window err", 128'(er), 128'd1);
        chk(!eng_busy && kern_outst == 16'd0, "R4 no launch from bad access",
            128'(kern_outst), 128'd0);

        // Vector table: R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            load_desc(TV_G[v], TV_W[v]);
            wr(BASE, 4'd8, 64'(v) * 64'h1234_5678_9ABC, er);
            launches++;
            chk(!er, "R5 launch ok", 128'(er), 128'd0);
            wait_push(got);
            chk(got, "R10 push seen", 128'(got), 128'd1);
            chk_rec($sformatf("R5 R6 vec%0d", v), exp_id, TV_C[v], TV_T[v]);
            exp_id++;
            chk(kern_outst == 16'(v + 1) && disp_active, "R8 outstanding/active",
                128'(kern_outst), 128'(v + 1));
            @(posedge clk);
        end

        rdd(BASE, 4'd8, rd, er);
        chk(rd == 64'd1, "R8 R2 status active", 128'(rd), 128'd1);

        // Push meets held launch: R9 R10 R11
        q_full = 1'b1;
        load_desc(TV_G[0], TV_W[0]);
        acc(1'b1, BASE, 4'd4, 64'd0, rd, er, w1);
        launches++;
        chk(w1 == 0, "R9 idle launch no wait", 128'(w1), 128'd0);
        repeat (150) @(negedge clk);
        #1;
        chk(eng_busy && !rec_push, "R10 held while full", 128'(rec_push), 128'd0);
        chk_rec("R10 waiting", exp_id, TV_C[0], TV_T[0]);
        load_desc(TV_G[1], TV_W[1]);
        acc(1'b1, BASE + 32'd8, 4'd4, {32'd0, TV_G[1][0]}, rd, er, w2);
        chk(w2 == 0, "R9 desc write during busy", 128'(w2), 128'd0);
        chk_rec("R11 record unchanged", exp_id, TV_C[0], TV_T[0]);
        fork
            begin
                acc(1'b1, BASE, 4'd8, 64'hDEAD, rd, er, w1);
                launches++;
            end
            begin
                repeat (20) @(negedge clk);
                #1;
                chk(!rec_push, "R10 no push while full", 128'(rec_push), 128'd0);
                @(negedge clk);
                q_full = 1'b0;
                #1;
                chk(rec_push, "R10 push on release", 128'(rec_push), 128'd1);
                chk_rec("R10 R11 released", exp_id, TV_C[0], TV_T[0]);
            end
        join
        exp_id++;
        chk(w1 >= 20, "R9 launch stalled while busy", 128'(w1), 128'd20);
        wait_push(got);
        chk(got, "R10 second push", 128'(got), 128'd1);
        chk_rec("R5 R11 second", exp_id, TV_C[1], TV_T[1]);
        @(posedge clk);
        repeat (5) @(negedge clk);
        chk(pushes == launches, "R10 one push per launch", 128'(pushes), 128'(launches));
        chk(kern_outst == 16'(launches), "R8 final outstanding", 128'(kern_outst),
            128'(launches));

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule